// File: doc/BRIEF.md
# Pipelined Partial-Product Multiplier

This block multiplies two 32-bit operands in a three-stage pipeline. It returns one 32-bit half of the 64-bit product. A mode input chooses between two's-complement and unsigned interpretation of the operands. A half-select input chooses whether the upper or the lower word of the product is returned. Both inputs, along with the operands, are sampled on the cycle a start pulse is accepted.

Inside, each operand is split into two 16-bit halves, and the block forms four 16x16 partial products. Signed operation does not use sign extension. Instead, the top bit of each operand is inverted when the operand is captured, which reads it as an offset-binary value. One folded correction term is then added into the final sum. A three-bit occupancy shift register follows each accepted start down the pipe. It raises busy for the two cycles after acceptance and pulses done in the third cycle, when the registered result slice becomes valid. A start pulse that arrives while busy is high is dropped. The result register holds its value until the next operation completes.

Top module: `ppmul_top`

## Requirements
- R1: In unsigned mode (`is_signed`=0), the result equals bits 31:0 (`take_high`=0) or bits 63:32 (`take_high`=1) of the unsigned 64-bit product of `opa` and `opb`.
- R2: In signed mode (`is_signed`=1), the result equals the selected half of the two's-complement 64-bit product of `opa` and `opb`. This includes the extreme values 0x80000000 and 0x7FFFFFFF.
- R3: The low result word (`take_high`=0) is identical in signed and unsigned modes for the same operands.
- R4: `take_high`=1 selects product bits 63:32 and `take_high`=0 selects bits 31:0. The choice is the value sampled on the accepted start cycle.
- R5: After a start is accepted on clock edge E, `busy` is high for the two cycles following E. `done` is high for exactly the one cycle after edge E+2, and the new result is present in that same cycle. `busy` and `done` are never high together.
- R6: `result` does not change except in a cycle where `done` is high. It holds its value through any number of idle cycles.
- R7: While `rst_n` is low, `busy`, `done` and `result` are 0. An operation that is in flight when reset is asserted never produces a `done`.
- R8: A start that is sampled while `busy` is high is ignored. It produces no extra `done`, and the pending result is the one from the accepted operation.
- R9: Operands, mode and half-select are only sampled on the accepted start cycle. Changing them afterwards does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to `clk` |
| start | input | 1 | Request a multiply; accepted when `busy` is low |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| take_high | input | 1 | 1: return product bits 63:32, 0: return bits 31:0 |
| opa | input | 32 | Multiplicand |
| opb | input | 32 | Multiplier |
| busy | output | 1 | Pipeline occupied in stages one or two |
| done | output | 1 | One-cycle pulse; `result` holds a new value |
| result | output | 32 | Registered selected half of the product |

## Verification
On every cycle, the assertions check the tracker's timing: an accepted start raises busy, done is a single pulse that follows an accepted start by three cycles, busy and done are mutually exclusive, and the result changes only when done is high. Arithmetic correctness cannot be seen by a temporal property. Only the bench's scenarios can show it: they compare both product halves, in both modes, against a wide-integer reference over corner operands and random pairs. Only directed scenarios can show that a start sampled while busy is dropped, that inputs changed after acceptance have no effect, and that a reset in mid-flight suppresses the pending completion.

// File: rtl/ppmul_pkg.sv
package ppmul_pkg;
  // Number of occupancy stages tracked behind an accepted start.
  localparam int unsigned TRACK_DEPTH = 3;

  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } half_sel_e;
endpackage

// File: rtl/ppmul_tracker.sv
module ppmul_tracker #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic [DEPTH-1:0] occ
);
  logic [DEPTH-1:0] occ_d;
  logic [DEPTH-1:0] occ_q;

  always_comb begin
    occ_d = {occ_q[DEPTH-2:0], go};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assign occ = occ_q;
endmodule

// File: rtl/ppmul_operand_stage.sv
module ppmul_operand_stage #(
  parameter int unsigned OPW = 32
) (
  input  logic           clk,
  input  logic           load,
  input  logic           is_signed,
  input  logic [OPW-1:0] a_in,
  input  logic [OPW-1:0] b_in,
  output logic [OPW-1:0] a_q,
  output logic [OPW-1:0] b_q,
  output logic           sgn_q
);
  logic [OPW-1:0] a_d, b_d;

  // Offset-binary view of signed operands: invert the top bit.
  always_comb begin
    a_d = {a_in[OPW-1] ^ is_signed, a_in[OPW-2:0]};
    b_d = {b_in[OPW-1] ^ is_signed, b_in[OPW-2:0]};
  end

  always_ff @(posedge clk) begin
    if (load) begin
      a_q   <= a_d;
      b_q   <= b_d;
      sgn_q <= is_signed;
    end
  end
endmodule

// File: rtl/ppmul_partial_stage.sv
module ppmul_partial_stage #(
  parameter int unsigned OPW = 32
) (
  input  logic           clk,
  input  logic           load,
  input  logic [OPW-1:0] a_q,
  input  logic [OPW-1:0] b_q,
  input  logic           sgn_q,
  output logic [OPW-1:0] hh_q,
  output logic [OPW-1:0] ll_q,
  output logic [OPW:0]   cross_q,
  output logic [OPW:0]   corr_q
);
  localparam int unsigned H = OPW / 2;
  localparam logic [OPW:0] CORR_BASE = (OPW+1)'(1) << (OPW - 1);

  logic [OPW-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [OPW-1:0] hh_d, ll_d, p_hl, p_lh;
  logic [OPW:0]   cross_d, corr_d;

  always_comb begin
    a_hi    = {{H{1'b0}}, a_q[OPW-1:H]};
    a_lo    = {{H{1'b0}}, a_q[H-1:0]};
    b_hi    = {{H{1'b0}}, b_q[OPW-1:H]};
    b_lo    = {{H{1'b0}}, b_q[H-1:0]};
    hh_d    = a_hi * b_hi;
    ll_d    = a_lo * b_lo;
    p_hl    = a_hi * b_lo;
    p_lh    = a_lo * b_hi;
    cross_d = {1'b0, p_hl} + {1'b0, p_lh};
    // Folded offset correction; wraps modulo 2^(OPW+1), which is exact
    // once it is scaled into the product's upper field.
    corr_d  = sgn_q ? (CORR_BASE - ({1'b0, a_q} + {1'b0, b_q})) : '0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      hh_q    <= hh_d;
      ll_q    <= ll_d;
      cross_q <= cross_d;
      corr_q  <= corr_d;
    end
  end
endmodule

// File: rtl/ppmul_sum_stage.sv
module ppmul_sum_stage #(
  parameter int unsigned OPW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           take_high,
  input  logic [OPW-1:0] hh_q,
  input  logic [OPW-1:0] ll_q,
  input  logic [OPW:0]   cross_q,
  input  logic [OPW:0]   corr_q,
  output logic [OPW-1:0] slice_q
);
  localparam int unsigned H  = OPW / 2;
  localparam int unsigned UW = 2 * OPW - H;

  logic [UW-1:0]    upper;
  logic [2*OPW-1:0] prod;
  logic [OPW-1:0]   slice_d;

  always_comb begin
    upper = {{(UW-H){1'b0}}, ll_q[OPW-1:H]}
          + {{(UW-OPW-1){1'b0}}, cross_q}
          + {corr_q, {(OPW-1-H){1'b0}}}
          + {hh_q, {H{1'b0}}};
    prod    = {upper, ll_q[H-1:0]};
    slice_d = take_high ? prod[2*OPW-1:OPW] : prod[OPW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slice_q <= '0;
    else if (load) slice_q <= slice_d;
  end
endmodule

// File: rtl/ppmul_top.sv
module ppmul_top
  import ppmul_pkg::*;
#(
  parameter int unsigned OPW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_signed,
  input  logic           take_high,
  input  logic [OPW-1:0] opa,
  input  logic [OPW-1:0] opb,
  output logic           busy,
  output logic           done,
  output logic [OPW-1:0] result
);
  localparam int unsigned D = TRACK_DEPTH;

  logic [D-1:0]   occ;
  logic           go;
  half_sel_e      half_q;
  logic [OPW-1:0] a_q, b_q, hh_q, ll_q;
  logic           sgn_q;
  logic [OPW:0]   cross_q, corr_q;

  assign busy = |occ[D-2:0];
  assign done = occ[D-1];
  assign go   = start & ~busy;

  always_ff @(posedge clk) begin
    if (go) half_q <= take_high ? HALF_HIGH : HALF_LOW;
  end

  ppmul_tracker #(.DEPTH(D)) u_track (
    .clk(clk), .rst_n(rst_n), .go(go), .occ(occ)
  );

  ppmul_operand_stage #(.OPW(OPW)) u_s1 (
    .clk(clk), .load(go), .is_signed(is_signed),
    .a_in(opa), .b_in(opb), .a_q(a_q), .b_q(b_q), .sgn_q(sgn_q)
  );

  ppmul_partial_stage #(.OPW(OPW)) u_s2 (
    .clk(clk), .load(occ[0]), .a_q(a_q), .b_q(b_q), .sgn_q(sgn_q),
    .hh_q(hh_q), .ll_q(ll_q), .cross_q(cross_q), .corr_q(corr_q)
  );

  ppmul_sum_stage #(.OPW(OPW)) u_s3 (
    .clk(clk), .rst_n(rst_n), .load(occ[1]),
    .take_high(half_q == HALF_HIGH),
    .hh_q(hh_q), .ll_q(ll_q), .cross_q(cross_q), .corr_q(corr_q),
    .slice_q(result)
  );
endmodule

// File: rtl/ppmul_checker.sv
module ppmul_checker #(
  parameter int unsigned OPW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [OPW-1:0] result
);
  // R5: an accepted start occupies the pipe on the next cycle
  p_busy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R5: busy and done are never high together
  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done only follows a start sampled while not busy, three cycles back
  p_done_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(start, 3) && !$past(busy, 3)));

  // R6: the result only moves in a done cycle
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind ppmul_top ppmul_checker #(.OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .result(result)
);

// File: tb/ppmul_top_tb.sv
`timescale 1ns/1ps
module ppmul_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic        take_high = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        busy, done;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ppmul_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .take_high(take_high), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result)
  );

  localparam int NV = 10;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'h0000_0001},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h8000_0000},
    {32'h7FFF_FFFF, 32'h7FFF_FFFF},
    {32'h7FFF_FFFF, 32'h8000_0000},
    {32'hFFFF_FFFF, 32'h0000_0001},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'hDEAD_BEEF, 32'h0BAD_F00D},
    {32'h0001_FFFF, 32'h0001_0001}
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [31:0] a,
                                           input logic [31:0] b,
                                           input bit sg);
    logic signed [63:0] sa, sb;
    if (sg) begin
      sa = $signed({{32{a[31]}}, a});
      sb = $signed({{32{b[31]}}, b});
      return sa * sb;
    end
    return {32'h0, a} * {32'h0, b};
  endfunction

  // Drives one operation, scrambles inputs after acceptance (R9),
  // checks the latency profile (R5) and returns the result slice.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input bit sg, input bit hi,
                        output logic [31:0] res);
    bit ok;
    @(negedge clk);
    start = 1'b1; opa = a; opb = b; is_signed = sg; take_high = hi;
    @(negedge clk);
    start = 1'b0; opa = $urandom; opb = $urandom;
    is_signed = ~sg; take_high = ~hi;
    ok = busy && !done;
    @(negedge clk);
    ok &= busy && !done;
    @(negedge clk);
    ok &= !busy && done;
    check(ok, "R5 busy/done timing", {30'h0, busy, done}, 32'h1);
    res = result;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r, r_lo_s, r_lo_u, held;
    logic [63:0] ep;
    bit ok;

    // R7: reset state
    #1;
    check(!busy && !done, "R7 reset flags", {30'h0, busy, done}, 32'h0);
    check(result == 32'h0, "R7 reset result", result, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R1, R2, R3, R4, R9
    for (int i = 0; i < NV; i++) begin
      logic [31:0] a, b;
      a = VEC[i][63:32];
      b = VEC[i][31:0];
      for (int m = 0; m < 2; m++) begin
        ep = ref_prod(a, b, m[0]);
        run_op(a, b, m[0], 1'b0, r);
        check(r == ep[31:0], m[0] ? "R2 signed low R4 R9" : "R1 unsigned low R4 R9",
              r, ep[31:0]);
        if (m == 0) r_lo_u = r; else r_lo_s = r;
        run_op(a, b, m[0], 1'b1, r);
        check(r == ep[63:32], m[0] ? "R2 signed high R4 R9" : "R1 unsigned high R4 R9",
              r, ep[63:32]);
      end
      check(r_lo_s == r_lo_u, "R3 low word mode independent", r_lo_s, r_lo_u);
    end

    // Random pairs: R1, R2
    for (int k = 0; k < 24; k++) begin
      logic [31:0] a, b;
      bit sg, hi;
      a = $urandom; b = $urandom; sg = k[0]; hi = k[1];
      ep = ref_prod(a, b, sg);
      run_op(a, b, sg, hi, r);
      check(r == (hi ? ep[63:32] : ep[31:0]), sg ? "R2 random" : "R1 random",
            r, hi ? ep[63:32] : ep[31:0]);
    end

    // R6: result held through idle cycles
    run_op(32'h0000_BEEF, 32'h0000_1000, 1'b0, 1'b0, held);
    ok = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      ok &= (result == held) && !done;
    end
    check(ok, "R6 result hold", result, held);

    // R8: start sampled while busy is dropped
    ep = ref_prod(32'h0000_0003, 32'h0000_0005, 1'b0);
    @(negedge clk);
    start = 1'b1; opa = 32'h3; opb = 32'h5; is_signed = 1'b0; take_high = 1'b0;
    @(negedge clk);
    opa = 32'h7; opb = 32'h9; take_high = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(done && result == ep[31:0], "R8 busy start ignored, result", result, ep[31:0]);
    ok = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      ok &= !done && !busy && (result == ep[31:0]);
    end
    check(ok, "R8 no extra completion", {30'h0, busy, done}, 32'h0);

    // R7: reset in flight suppresses completion
    @(negedge clk);
    start = 1'b1; opa = 32'h11; opb = 32'h22;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    #1;
    check(!busy && !done && result == 32'h0, "R7 async reset mid-op", result, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    ok = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      ok &= !done && !busy;
    end
    check(ok, "R7 no done after reset", {30'h0, busy, done}, 32'h0);

    // Operation works again after reset (R2 corner)
    ep = ref_prod(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, r);
    check(r == ep[63:32], "R2 post-reset signed high", r, ep[63:32]);

    summary();
  end
endmodule